// File: doc/BRIEF.md
# Bidirectional Row Scan Register

This block is the scan logic for the common (row) side of a 240-row LCD driver. A scan token is loaded serially and moves one stage per falling edge of the line pulse `lp`, so that one row at a time is selected. The `lr` input sets the direction of travel. Two cascade pins trade roles with the direction: one takes serial data in, the other passes the last stage out to the next driver in a chain.

Each row gets a 2-bit drive-level code. The code depends on the row's scan bit and on the frame-inversion input `fr`. A display-off input, active low, forces every row to the ground code and clears the scan state. After release, a fresh token is taken at the next falling edge of `lp`.

All logic runs on the system clock `clk`. The `lp` input is sampled on that clock, and its falling edge is detected there.

Top module: `row_scan`

## Requirements
- R1: After reset the scan register is all zero, so every row shows the non-select code for the current `fr`, and both cascade data outputs are 0.
- R2: With `lr`=1, each detected falling edge of `lp` moves every stage one row toward row 240 and loads `eio1_in` into row 1. `eio2_in` is ignored.
- R3: With `lr`=0, each detected falling edge of `lp` moves every stage one row toward row 1 and loads `eio2_in` into row 240. `eio1_in` is ignored.
- R4: With `lr`=1, `eio2_oe`=1 and `eio2_out` equals row 240's stage, while `eio1_oe`=0 and `eio1_out`=0. With `lr`=0 the roles swap: `eio1_out` equals row 1's stage. An input-role pin is modelled as a default-low input.
- R5: A selected row (scan bit 1), with display on, gives code 2'b11 (V0) when `fr`=1 and 2'b00 (VSS) when `fr`=0.
- R6: A non-selected row, with display on, gives code 2'b01 (V43) when `fr`=1 and 2'b10 (V12) when `fr`=0.
- R7: While `disp_off_n`=0, every row code is 2'b00 in the same cycle, and the register is cleared at the next clock. After release, rows show the non-select code, and the next `lp` falling edge loads the serial input.
- R8: The register changes on nothing but a detected `lp` falling edge, or a display-off clear. A rising edge of `lp`, or holding `lp` at either level, leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp | input | 1 | Line pulse; a falling edge advances the scan |
| lr | input | 1 | Direction: 1 = row 1 toward row 240, 0 = reverse |
| disp_off_n | input | 1 | Display off, active low |
| fr | input | 1 | Frame inversion signal |
| eio1_in | input | 1 | Cascade pin 1, input value (serial input when lr=1) |
| eio2_in | input | 1 | Cascade pin 2, input value (serial input when lr=0) |
| eio1_out | output | 1 | Cascade pin 1, output value (last stage when lr=0) |
| eio1_oe | output | 1 | Cascade pin 1, output enable |
| eio2_out | output | 1 | Cascade pin 2, output value (last stage when lr=1) |
| eio2_oe | output | 1 | Cascade pin 2, output enable |
| row_lvl | output | 2*ROWS | Per-row level code; row k is bits [2k-1:2k-2] |

## Verification
A wrong stage in the scan register shows at once on that row's level code, in the cycle after the `lp` fall that created it. The error then travels with the token. A token that is lost or duplicated appears as a selected-row count other than one. A shift in the wrong direction shows as the selected row moving away from where the bench expects it, on the first edge after the fault. A stage that stays set after display-off shows on the first check following release, because the bench expects every row to show the non-select code there.

// File: rtl/row_scan.sv
module row_scan #(
  parameter int ROWS = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp,
  input  logic              lr,
  input  logic              disp_off_n,
  input  logic              fr,
  input  logic              eio1_in,
  input  logic              eio2_in,
  output logic              eio1_out,
  output logic              eio1_oe,
  output logic              eio2_out,
  output logic              eio2_oe,
  output logic [2*ROWS-1:0] row_lvl
);

  localparam logic [1:0] LVL_VSS = 2'b00;
  localparam logic [1:0] LVL_V43 = 2'b01;
  localparam logic [1:0] LVL_V12 = 2'b10;
  localparam logic [1:0] LVL_V0  = 2'b11;

  logic [ROWS-1:0] scan;
  logic            lp_q;
  logic            lp_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lp_q <= 1'b0;
    else        lp_q <= lp;

  assign lp_fall = lp_q & ~lp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          scan <= '0;
    else if (!disp_off_n) scan <= '0;
    else if (lp_fall)
      scan <= lr ? {scan[ROWS-2:0], eio1_in} : {eio2_in, scan[ROWS-1:1]};

  assign eio1_oe  = ~lr;
  assign eio2_oe  = lr;
  assign eio1_out = ~lr & scan[0];
  assign eio2_out = lr & scan[ROWS-1];

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    assign row_lvl[2*k +: 2] = !disp_off_n ? LVL_VSS :
                               scan[k] ? (fr ? LVL_V0  : LVL_VSS) :
                                         (fr ? LVL_V43 : LVL_V12);
  end

  // R2
  fwd_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off_n && lp_fall && lr) |=>
      (scan[0] == $past(eio1_in)) && (scan[ROWS-1:1] == $past(scan[ROWS-2:0])));

  // R3
  rev_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off_n && lp_fall && !lr) |=>
      (scan[ROWS-1] == $past(eio2_in)) && (scan[ROWS-2:0] == $past(scan[ROWS-1:1])));

  // R7
  dispoff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off_n |=> (scan == '0));

  // R7
  dispoff_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off_n |-> (row_lvl == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off_n && !(lp_q && !lp)) |=> $stable(scan));

  // R4
  cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr |-> (eio2_oe && !eio1_oe && !eio1_out));

endmodule

// File: tb/tb_row_scan.sv
module tb_row_scan;
  localparam int N = 240;

  logic clk = 0, rst_n = 0, lp = 0, lr = 1, disp_off_n = 1, fr = 0;
  logic eio1_in = 0, eio2_in = 0;
  logic eio1_out, eio1_oe, eio2_out, eio2_oe;
  logic [2*N-1:0] row_lvl;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [N-1:0] m = '0;

  always #2.5 clk = ~clk;

  row_scan #(.ROWS(N)) dut (.*);

  function automatic logic [2*N-1:0] expv(logic [N-1:0] s, logic f, logic d);
    logic [2*N-1:0] v;
    for (int k = 0; k < N; k++)
      v[2*k +: 2] = !d ? 2'b00 : s[k] ? (f ? 2'b11 : 2'b00) : (f ? 2'b01 : 2'b10);
    return v;
  endfunction

  function automatic int count_sel(logic [2*N-1:0] v, logic f);
    int c = 0;
    for (int k = 0; k < N; k++) if (v[2*k +: 2] == (f ? 2'b11 : 2'b00)) c++;
    return c;
  endfunction

  task automatic chk_vec(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s row_lvl act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_pins(string req);
    logic e1o, e1e, e2o, e2e;
    e1e = ~lr; e2e = lr;
    e1o = lr ? 1'b0 : m[0];
    e2o = lr ? m[N-1] : 1'b0;
    chk_int({req, " eio"}, {eio1_oe, eio1_out, eio2_oe, eio2_out}, {e1e, e1o, e2e, e2o});
  endtask

  task automatic lp_edge(logic din, logic junk);
    @(negedge clk);
    if (lr) begin eio1_in = din; eio2_in = junk; end
    else    begin eio2_in = din; eio1_in = junk; end
    lp = 1;
    repeat (2) @(negedge clk);
    lp = 0;
    repeat (2) @(negedge clk);
    if (disp_off_n) m = lr ? {m[N-2:0], din} : {din, m[N-1:1]};
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    // R1 reset state
    fr = 1;
    @(negedge clk);
    chk_vec("R1 reset fr=1", row_lvl, expv('0, 1, 1));
    chk_int("R1 reset eio outs", {eio1_out, eio2_out}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 forward token sweep
    lr = 1; fr = 1;
    for (int i = 1; i <= N; i++) begin
      lp_edge(i == 1, 1'b1);
      chk_vec("R2 fwd", row_lvl, expv(m, fr, 1));
      chk_int("R2 one selected", count_sel(row_lvl, fr), 1);
    end
    chk_int("R4 fwd last stage out", eio2_out, 1);
    chk_pins("R4 fwd");
    lp_edge(1'b0, 1'b1);
    chk_vec("R2 token leaves", row_lvl, expv('0, fr, 1));
    chk_int("R4 fwd out after exit", eio2_out, 0);

    // R3 reverse token sweep
    lr = 0;
    for (int i = 1; i <= N; i++) begin
      fr = i[0];
      lp_edge(i == 1, 1'b1);
      chk_vec("R3 rev", row_lvl, expv(m, fr, 1));
      chk_int("R3 one selected", count_sel(row_lvl, fr), 1);
    end
    chk_int("R4 rev last stage out", eio1_out, 1);
    chk_pins("R4 rev");

    // R5 R6 level codes with fr both ways
    fr = 0; @(negedge clk);
    chk_vec("R5 R6 fr=0", row_lvl, expv(m, 0, 1));
    chk_int("R5 sel code fr=0", row_lvl[1:0], 2'b00);
    chk_int("R6 nonsel code fr=0", row_lvl[3:2], 2'b10);
    fr = 1; @(negedge clk);
    chk_int("R5 sel code fr=1", row_lvl[1:0], 2'b11);
    chk_int("R6 nonsel code fr=1", row_lvl[3:2], 2'b01);

    // R8 lp held high then low, no edge
    lp = 1; repeat (5) @(negedge clk);
    chk_vec("R8 lp high hold", row_lvl, expv(m, fr, 1));
    lp = 0; @(negedge clk);
    @(negedge clk);
    m = {1'b0, m[N-1:1]};
    chk_vec("R8 single fall", row_lvl, expv(m, fr, 1));
    repeat (5) @(negedge clk);
    chk_vec("R8 lp low hold", row_lvl, expv(m, fr, 1));

    // R7 display off
    lr = 1;
    for (int i = 0; i < 6; i++) lp_edge(1'b1, 1'b0);
    disp_off_n = 0;
    #1;
    chk_vec("R7 forced ground", row_lvl, '0);
    @(negedge clk);
    m = '0;
    lp_edge(1'b1, 1'b1);
    chk_vec("R7 no capture while off", row_lvl, '0);
    m = '0;
    disp_off_n = 1;
    @(negedge clk);
    chk_vec("R7 nonselect after release", row_lvl, expv('0, fr, 1));
    lp_edge(1'b1, 1'b0);
    chk_vec("R7 capture next fall", row_lvl, expv(m, fr, 1));
    chk_int("R7 row1 selected", row_lvl[1:0], 2'b11);

    // random mix
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lr = $urandom_range(0, 1);
      fr = $urandom_range(0, 1);
      if ($urandom_range(0, 19) == 0) begin
        disp_off_n = 0;
        #1;
        chk_vec("R7 rand off", row_lvl, '0);
        @(negedge clk);
        m = '0;
        disp_off_n = 1;
      end
      lp_edge($urandom_range(0, 1), $urandom_range(0, 1));
      chk_vec(lr ? "R2 rand" : "R3 rand", row_lvl, expv(m, fr, 1));
      chk_pins("R4 rand");
    end
    finish_up();
  end
endmodule